// File: doc/BRIEF.md
# Programmable Interrupt Aggregator

This block gathers a parameterised set of interrupt request lines, up to 32, into one request line for a processor. Each source has a status bit. The status bit is captured from the source line, and a per-source build-time choice decides how: a level source's status bit follows the line, while an edge source's status bit is set by a rising edge and stays set until software clears it. An enable register masks status into a pending set. The lowest-numbered pending source is reported as a vector index. The processor request is raised while pending work exists and the output gate is open.

Software reaches the block through a simple synchronous register port with a write strobe, a byte address, write data and combinational read data. Registers sit on word-aligned addresses. The enable register can be changed in three ways: a plain write, a write-one-to-set port and a write-one-to-clear port. Status is cleared through a write-one-to-clear acknowledge port. A two-bit master control register holds two separate gates: bit 0 gates the request output and bit 1 gates input capture.

Top module: `irq_hub`

## Requirements
- R1: The pending register (address 0x04) always reads as the bitwise AND of status and enable.
- R2: A write to the acknowledge port (0x0C) clears each status bit whose written bit is 1 and leaves the other status bits unchanged.
- R3: A write to 0x08 loads enable. A write to 0x10 ORs the written value into enable. A write to 0x14 clears the enable bits whose written bit is 1.
- R4: `irq_out` is high exactly when master bit 0 is 1, master bit 1 is 1 and at least one pending bit is set.
- R5: While master bit 1 (register 0x1C) is 0, source changes leave status unchanged and `irq_out` stays low.
- R6: For a source whose `EDGE_MASK` bit is 0 (level), the status bit equals the source line as sampled at the previous clock edge, while capture is enabled.
- R7: For a source whose `EDGE_MASK` bit is 1 (edge), a 0-to-1 transition seen between two clock edges sets the status bit. A falling line does not clear the bit, and a line held high does not set it again after an acknowledge.
- R8: The vector register (0x18) reads as the index of the lowest set pending bit, or as 0xFFFFFFFF when no bit is pending.
- R9: Writes to pending (0x04), vector (0x18), misaligned addresses and addresses at or above 0x20 change no register. Reads from misaligned or unmapped addresses return zero.
- R10: After reset, status, enable, master control and `irq_out` are all zero.
- R11: A write to 0x00 loads status directly. When capture is enabled, level bits are then overwritten by the source lines. An edge rising in the same cycle as its acknowledge leaves the status bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for registers and source sampling |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NSRC | Interrupt source lines, one per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Request line to the processor |

## Verification
The main sweep uses eight sources: four level sources and four edge sources. All 256 status patterns are produced by driving the source lines. For each status pattern, all 256 enable values are tried, so pending, vector and request are checked for every status-by-enable pair. This sweep separates an AND from other masking errors and exposes any priority order other than lowest index first, including the empty-pending case. Directed sequences cover the remaining behaviour: acknowledge with partial masks, edge lines that fall or stay high after acknowledge, an edge that rises during its own acknowledge, each master control combination, and writes to read-only or unmapped addresses.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;
    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        SEL_STAT  = 3'd0,
        SEL_PEND  = 3'd1,
        SEL_ENAB  = 3'd2,
        SEL_ACK   = 3'd3,
        SEL_SETEN = 3'd4,
        SEL_CLREN = 3'd5,
        SEL_VEC   = 3'd6,
        SEL_CTRL  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     valid;
        reg_sel_e sel;
    } wr_cmd_t;

    typedef struct packed {
        logic capture_en;
        logic out_en;
    } master_t;

    function automatic wr_cmd_t make_cmd(input logic we, input logic hit, input logic [2:0] word);
        wr_cmd_t c;
        c.valid = we && hit;
        c.sel   = reg_sel_e'(word);
        return c;
    endfunction
endpackage

// File: rtl/irq_hub_status.sv
`timescale 1ns/1ps
module irq_hub_status
    import irq_hub_pkg::*;
#(
    parameter int               NSRC      = 32,
    parameter logic [NSRC-1:0]  EDGE_MASK = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    input  wr_cmd_t         cmd,
    input  logic [NSRC-1:0] wdata,
    input  logic            capture_en,
    output logic [NSRC-1:0] stat_q
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] base;
    logic [NSRC-1:0] nxt;

    assign rise = src & ~prev_q;

    always_comb begin
        base = stat_q;
        if (cmd.valid && cmd.sel == SEL_STAT) base = wdata;
        if (cmd.valid && cmd.sel == SEL_ACK)  base = stat_q & ~wdata;
        nxt = base;
        if (capture_en)
            nxt = ((base | rise) & EDGE_MASK) | (src & ~EDGE_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            prev_q <= '0;
        end else begin
            stat_q <= nxt;
            prev_q <= src;
        end
    end
endmodule

// File: rtl/irq_hub_enable.sv
`timescale 1ns/1ps
module irq_hub_enable
    import irq_hub_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  wr_cmd_t         cmd,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] en_q,
    output master_t         mst_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            mst_q <= '0;
        end else if (cmd.valid) begin
            unique case (cmd.sel)
                SEL_ENAB:  en_q  <= wdata;
                SEL_SETEN: en_q  <= en_q | wdata;
                SEL_CLREN: en_q  <= en_q & ~wdata;
                SEL_CTRL:  mst_q <= master_t'(wdata[1:0]);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_hub_vector.sv
`timescale 1ns/1ps
module irq_hub_vector #(
    parameter int NSRC  = 32,
    parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  pend,
    output logic             vld,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                vld = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int               NSRC      = 32,
    parameter logic [NSRC-1:0]  EDGE_MASK = '0,
    parameter int               ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   irq_src,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_out
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic            hit;
    wr_cmd_t         cmd;
    logic [NSRC-1:0] stat_q;
    logic [NSRC-1:0] en_q;
    master_t         mst_q;
    logic [NSRC-1:0] pend;
    logic            vec_vld;
    logic [IDX_W-1:0] vec_idx;

    assign hit = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:5] == '0);
    assign cmd = make_cmd(bus_we, hit, bus_addr[4:2]);

    irq_hub_status #(.NSRC(NSRC), .EDGE_MASK(EDGE_MASK)) u_stat (
        .clk(clk), .rst(rst), .src(irq_src), .cmd(cmd),
        .wdata(bus_wdata[NSRC-1:0]), .capture_en(mst_q.capture_en), .stat_q(stat_q)
    );

    irq_hub_enable #(.NSRC(NSRC)) u_en (
        .clk(clk), .rst(rst), .cmd(cmd), .wdata(bus_wdata[NSRC-1:0]),
        .en_q(en_q), .mst_q(mst_q)
    );

    assign pend = stat_q & en_q;

    irq_hub_vector #(.NSRC(NSRC), .IDX_W(IDX_W)) u_vec (
        .pend(pend), .vld(vec_vld), .idx(vec_idx)
    );

    assign irq_out = mst_q.out_en && mst_q.capture_en && (pend != '0);

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (reg_sel_e'(bus_addr[4:2]))
                SEL_STAT: bus_rdata[NSRC-1:0] = stat_q;
                SEL_PEND: bus_rdata[NSRC-1:0] = pend;
                SEL_ENAB: bus_rdata[NSRC-1:0] = en_q;
                SEL_VEC: begin
                    if (vec_vld) bus_rdata[IDX_W-1:0] = vec_idx;
                    else         bus_rdata = '1;
                end
                SEL_CTRL: bus_rdata[1:0] = mst_q;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_hub_chk.sv
`timescale 1ns/1ps
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int               NSRC      = 32,
    parameter logic [NSRC-1:0]  EDGE_MASK = '0,
    parameter int               ADDR_W    = 8,
    parameter int               IDX_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic [NSRC-1:0]   src,
    input logic              irq,
    input logic [NSRC-1:0]   stat_q,
    input logic [NSRC-1:0]   en_q,
    input logic [1:0]        mst,
    input logic [NSRC-1:0]   pend,
    input logic              vec_vld,
    input logic [IDX_W-1:0]  vec_idx
);
    logic     ok;
    reg_sel_e s;
    logic     wr_ack_or_stat;
    assign ok = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:5] == '0);
    assign s  = reg_sel_e'(addr[4:2]);
    assign wr_ack_or_stat = we && ok && (s == SEL_ACK || s == SEL_STAT);

    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mst == 2'b11) && (pend != '0));

    assert_cap_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!mst[1] && !we) |=> $stable(stat_q));

    assert_level_follow_R6: assert property (@(posedge clk) disable iff (rst)
        $past(mst[1]) |-> ((stat_q ^ $past(src)) & ~EDGE_MASK) == '0);

    assert_edge_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ((($past(stat_q) & ~stat_q) & EDGE_MASK) != '0) |-> $past(wr_ack_or_stat));

    assert_vec_lowest_R8: assert property (@(posedge clk) disable iff (rst)
        vec_vld |-> pend[vec_idx] && ((pend & ~({NSRC{1'b1}} << vec_idx)) == '0));

    assert_vec_none_R8: assert property (@(posedge clk) disable iff (rst)
        !vec_vld |-> (pend == '0));

    assert_seten_R3: assert property (@(posedge clk) disable iff (rst)
        (we && ok && s == SEL_SETEN) |=> ((en_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

    assert_ro_write_R9: assert property (@(posedge clk) disable iff (rst)
        (we && (!ok || s == SEL_PEND || s == SEL_VEC)) |=> $stable(en_q) && $stable(mst));
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC), .EDGE_MASK(EDGE_MASK), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .src(irq_src), .irq(irq_out), .stat_q(stat_q), .en_q(en_q), .mst(mst_q),
    .pend(pend), .vec_vld(vec_vld), .vec_idx(vec_idx)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;
    localparam int         NSRC = 8;
    localparam logic [7:0] EDGE = 8'hF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  src = '0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_hub #(.NSRC(NSRC), .EDGE_MASK(EDGE), .ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .irq_src(src), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.4;
        d = rdata;
    endtask

    task automatic drive(input logic [7:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
    endtask

    function automatic logic [31:0] lowest(input logic [7:0] p);
        for (int i = 0; i < 8; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  p;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        rd(8'h00, v); chk("R10 status", v, 0);
        rd(8'h08, v); chk("R10 enable", v, 0);
        rd(8'h1C, v); chk("R10 master", v, 0);
        chk("R10 irq", 32'(irq), 0);

        wr(8'h1C, 32'h3);
        // Sweep: every status pattern against every enable value (R1 R4 R6 R7 R8)
        for (int s = 0; s < 256; s++) begin
            drive(8'h00);
            wr(8'h0C, 32'hFF);
            drive(8'(s));
            rd(8'h00, v); chk("R6/R7 sweep status", v, 32'(s));
            for (int e = 0; e < 256; e++) begin
                wr(8'h08, 32'(e));
                p = 8'(s) & 8'(e);
                rd(8'h04, v); chk("R1 pending", v, 32'(p));
                rd(8'h18, v); chk("R8 vector", v, lowest(p));
                chk("R4 irq", 32'(irq), 32'(p != 0));
            end
        end

        // R2 acknowledge, R7 edge hold after fall
        drive(8'h00); wr(8'h0C, 32'hFF);
        drive(8'hF0); drive(8'h00);
        rd(8'h00, v); chk("R7 edge kept after fall", v, 32'hF0);
        wr(8'h0C, 32'h30);
        rd(8'h00, v); chk("R2 partial ack", v, 32'hC0);
        wr(8'h0C, 32'h00);
        rd(8'h00, v); chk("R2 zero ack", v, 32'hC0);
        wr(8'h0C, 32'hFF);

        // R7 held-high edge not re-set after ack
        drive(8'h10);
        rd(8'h00, v); chk("R7 rise sets", v, 32'h10);
        wr(8'h0C, 32'h10);
        drive(8'h10);
        rd(8'h00, v); chk("R7 held high stays clear", v, 32'h00);
        drive(8'h00); drive(8'h10);
        rd(8'h00, v); chk("R7 new rise sets", v, 32'h10);

        // R11 rise during own ack keeps the bit
        drive(8'h00); wr(8'h0C, 32'hFF);
        @(negedge clk);
        src = 8'h20; we = 1'b1; addr = 8'h0C; wdata = 32'h20;
        @(negedge clk);
        we = 1'b0;
        rd(8'h00, v); chk("R11 rise beats ack", v, 32'h20);

        // R3 enable ports
        wr(8'h08, 32'h0F);
        wr(8'h10, 32'h30);
        rd(8'h08, v); chk("R3 set-enable", v, 32'h3F);
        wr(8'h14, 32'h05);
        rd(8'h08, v); chk("R3 clear-enable", v, 32'h3A);

        // R4/R5 master gates
        wr(8'h08, 32'hFF);
        rd(8'h04, v); chk("R1 pending before gate test", v, 32'h20);
        wr(8'h1C, 32'h1);
        chk("R5 irq low capture off", 32'(irq), 0);
        drive(8'h0F);
        rd(8'h00, v); chk("R5 inputs ignored", v, 32'h20);
        wr(8'h1C, 32'h2);
        chk("R4 irq low out gate off", 32'(irq), 0);
        wr(8'h1C, 32'h3);
        chk("R4 irq high both gates", 32'(irq), 1);

        // R11 direct status load, then level overwrite
        wr(8'h1C, 32'h1);
        drive(8'h00);
        wr(8'h00, 32'hA5);
        rd(8'h00, v); chk("R11 status load", v, 32'hA5);
        wr(8'h1C, 32'h3);
        @(negedge clk);
        rd(8'h00, v); chk("R11 level overwrite", v, 32'hA0);

        // R9 ignored writes and unmapped reads
        wr(8'h08, 32'h11);
        wr(8'h04, 32'hFF);
        wr(8'h18, 32'hFF);
        wr(8'h20, 32'hFF);
        wr(8'h09, 32'hFF);
        rd(8'h08, v); chk("R9 enable unchanged", v, 32'h11);
        rd(8'h00, v); chk("R9 status unchanged", v, 32'hA0);
        rd(8'h1C, v); chk("R9 master unchanged", v, 32'h3);
        rd(8'h20, v); chk("R9 unmapped read", v, 0);
        rd(8'h01, v); chk("R9 misaligned read", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule